// File: doc/BRIEF.md
# Clock Root Shadowed Configuration Registers

This block is the register front end of a single clock root. Software writes the source select, the pre-divider, the mode and the three fractional-divider values over a simple word-addressed write bus with a combinational read path. Each write lands only in a shadow copy and raises a pending-change flag for that register. The clock generator sees none of these writes until software requests an update.

An update copies every shadow register into the active set on one clock edge, so the generator never sees a mix of old and new settings. The request bit then drops one cycle later, and polling software sees the change complete. The command word also carries a root-enable bit and a read-only status bit fed from the generator. The generator asserts that status bit while the root is stopped.

Top module: `clkroot_cfg_regs`

## Requirements
- R1: After reset every readable register is zero except command bit 31, root enable is 0, and the active outputs show bypass (mode 0) with pre-divider field 0, which divides by one.
- R2: A write to the configuration (offset 0x4), M (0x8), N (0xC) or D (0x10) word is visible on read at the next cycle and leaves every active output unchanged.
- R3: Such a write sets its pending flag in the command word (offset 0x0): bit 4 for configuration, bit 5 for N, bit 6 for M, bit 7 for D.
- R4: Writing 1 to command bit 0 makes bit 0 read 1. On the next edge all shadow values are copied to the active outputs together, and all pending flags clear.
- R5: Command bit 0 reads 0 again one cycle after the copy, so an update completes within three cycles of the request.
- R6: A shadow write on the same edge as the copy is not part of that copy, and its pending flag stays set.
- R7: Command bit 1 is root enable. It is written directly (not shadowed), reads back, and drives the enable output from the cycle after the write.
- R8: Command bit 31 reads the root-off status input (0 means running). In the configuration word, bits DIV_W-1:0 hold the pre-divider, bits 10:8 the source and bits 13:12 the mode. M, N and D keep MND_W low bits, and every other bit reads 0.
- R9: Writes to command bits other than 0 and 1 have no effect, and writing 0 to bit 0 neither cancels nor starts an update.
- R10: Writes to word offsets above 0x10 change nothing, and those offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | ADDR_W | Byte address, low two bits ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| root_off_i | input | 1 | Generator status, 1 while the root is stopped |
| root_en_o | output | 1 | Root enable to the generator |
| act_prediv_o | output | DIV_W | Active pre-divider field |
| act_src_o | output | 3 | Active source select |
| act_mode_o | output | 2 | Active mode (0 bypass, 2 dual-edge fractional) |
| act_m_o | output | MND_W | Active M value |
| act_n_o | output | MND_W | Active N value |
| act_d_o | output | MND_W | Active D value |

## Verification
On every cycle, the assertions check several timing rules. The active outputs hold still outside a commit, and a commit copies exactly the shadow values of the cycle before. A pending flag raised by a write survives a coincident commit, the update bit falls one cycle after the copy, and root enable follows the written bit. The assertions cannot show the field layout of the read words, the masking of unused bits, the pending-flag bit order, the decode of unmapped offsets or the reset values. The bench covers those by exhaustive sweeps of the configuration fields and of all M, N and D values, comparing against its own arithmetic model.

// File: rtl/clkroot_pkg.sv
package clkroot_pkg;

  // Word indices on the bus (byte offset / 4)
  localparam int unsigned W_CMD = 0;
  localparam int unsigned W_CFG = 1;
  localparam int unsigned W_M   = 2;
  localparam int unsigned W_N   = 3;
  localparam int unsigned W_D   = 4;

  typedef enum logic [1:0] {
    UPD_IDLE   = 2'd0,
    UPD_COMMIT = 2'd1,
    UPD_ACK    = 2'd2
  } upd_state_e;

  // Build the configuration read word from its fields.
  function automatic logic [31:0] pack_cfg(input logic [7:0] div,
                                           input logic [2:0] src,
                                           input logic [1:0] mode);
    return {18'b0, mode, 1'b0, src, div};
  endfunction

  // Shadow write strobes are ordered {D,N,M,CFG}; pending flags are
  // ordered {D,M,N,CFG} (command bits 7..4).
  function automatic logic [3:0] wr_to_pending(input logic [3:0] wr);
    return {wr[3], wr[1], wr[2], wr[0]};
  endfunction

endpackage

// File: rtl/clkroot_shadow_bank.sv
module clkroot_shadow_bank #(
  parameter int unsigned DIV_W = 5,
  parameter int unsigned MND_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [3:0]             wr_i,      // 0 cfg, 1 M, 2 N, 3 D
  input  logic [31:0]            wdata_i,
  output logic [DIV_W-1:0]       div_o,
  output logic [2:0]             src_o,
  output logic [1:0]             mode_o,
  output logic [2:0][MND_W-1:0]  mnd_o      // 0 M, 1 N, 2 D
);

  localparam logic [31:0] MND_MASK = (32'(1) << MND_W) - 32'(1);
  localparam logic [31:0] DIV_MASK = (32'(1) << DIV_W) - 32'(1);
  localparam logic [31:0] USED     = MND_MASK | DIV_MASK | 32'h0000_3700;

  logic unused_wdata;
  assign unused_wdata = ^(wdata_i & ~USED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_o  <= '0;
      src_o  <= '0;
      mode_o <= '0;
    end else if (wr_i[0]) begin
      div_o  <= wdata_i[DIV_W-1:0];
      src_o  <= wdata_i[10:8];
      mode_o <= wdata_i[13:12];
    end
  end

  for (genvar g = 0; g < 3; g++) begin : g_mnd
    logic [MND_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           q <= '0;
      else if (wr_i[g + 1]) q <= wdata_i[MND_W-1:0];
    end
    assign mnd_o[g] = q;
  end

endmodule

// File: rtl/clkroot_dirty_track.sv
module clkroot_dirty_track #(
  parameter int unsigned NREG = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREG-1:0] set_i,
  input  logic            clr_i,
  output logic [NREG-1:0] dirty_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dirty_o <= '0;
    else        dirty_o <= (dirty_o & ~{NREG{clr_i}}) | set_i;
  end

  // R6: a write on the commit edge keeps its flag
  a_r6_set_survives_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((dirty_o & $past(set_i)) == $past(set_i)));

  // R4: a commit with no coincident write leaves nothing pending
  a_r4_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && set_i == '0) |=> (dirty_o == '0));

endmodule

// File: rtl/clkroot_update_ctrl.sv
module clkroot_update_ctrl
  import clkroot_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic busy_o,
  output logic commit_o
);

  upd_state_e st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= UPD_IDLE;
    else begin
      unique case (st)
        UPD_IDLE:   if (req_i) st <= UPD_COMMIT;
        UPD_COMMIT: st <= UPD_ACK;
        UPD_ACK:    st <= UPD_IDLE;
        default:    st <= UPD_IDLE;
      endcase
    end
  end

  assign busy_o   = (st != UPD_IDLE);
  assign commit_o = (st == UPD_COMMIT);

  // R4: an accepted request commits on the next edge
  a_r4_req_commits: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !busy_o) |=> commit_o);

  // R5: update bit stays up one cycle past the commit, then drops
  a_r5_bit_drops: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> (busy_o && !commit_o) ##1 !busy_o);

endmodule

// File: rtl/clkroot_active_bank.sv
module clkroot_active_bank #(
  parameter int unsigned DIV_W = 5,
  parameter int unsigned MND_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_i,
  input  logic [DIV_W-1:0]      div_i,
  input  logic [2:0]            src_i,
  input  logic [1:0]            mode_i,
  input  logic [2:0][MND_W-1:0] mnd_i,
  output logic [DIV_W-1:0]      div_o,
  output logic [2:0]            src_o,
  output logic [1:0]            mode_o,
  output logic [2:0][MND_W-1:0] mnd_o
);

  // Reset state: bypass mode, pre-divider field 0 (divide by one)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_o  <= '0;
      src_o  <= '0;
      mode_o <= '0;
      mnd_o  <= '0;
    end else if (load_i) begin
      div_o  <= div_i;
      src_o  <= src_i;
      mode_o <= mode_i;
      mnd_o  <= mnd_i;
    end
  end

  // R2: generator settings move only on a commit
  a_r2_hold_outside_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable({div_o, src_o, mode_o, mnd_o}));

endmodule

// File: rtl/clkroot_cfg_regs.sv
module clkroot_cfg_regs
  import clkroot_pkg::*;
#(
  parameter int unsigned DIV_W  = 5,   // 1..8
  parameter int unsigned MND_W  = 8,   // 1..32
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              root_off_i,
  output logic              root_en_o,
  output logic [DIV_W-1:0]  act_prediv_o,
  output logic [2:0]        act_src_o,
  output logic [1:0]        act_mode_o,
  output logic [MND_W-1:0]  act_m_o,
  output logic [MND_W-1:0]  act_n_o,
  output logic [MND_W-1:0]  act_d_o
);

  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              unused_addr_lsb;
  assign word            = bus_addr[ADDR_W-1:2];
  assign unused_addr_lsb = ^bus_addr[1:0];

  // ---------------- decode ----------------
  logic       wr_cmd;
  logic [3:0] sh_wr;       // 0 cfg, 1 M, 2 N, 3 D
  assign wr_cmd = bus_wr_en && (word == WORD_W'(W_CMD));
  for (genvar g = 0; g < 4; g++) begin : g_dec
    assign sh_wr[g] = bus_wr_en && (word == WORD_W'(W_CFG + g));
  end

  // ---------------- update handshake ----------------
  logic upd_req, upd_busy, commit;
  assign upd_req = wr_cmd && bus_wdata[0];

  clkroot_update_ctrl u_upd (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (upd_req),
    .busy_o   (upd_busy),
    .commit_o (commit)
  );

  // ---------------- shadow set ----------------
  logic [DIV_W-1:0]      sh_div;
  logic [2:0]            sh_src;
  logic [1:0]            sh_mode;
  logic [2:0][MND_W-1:0] sh_mnd;

  clkroot_shadow_bank #(.DIV_W(DIV_W), .MND_W(MND_W)) u_shadow (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (sh_wr),
    .wdata_i (bus_wdata),
    .div_o   (sh_div),
    .src_o   (sh_src),
    .mode_o  (sh_mode),
    .mnd_o   (sh_mnd)
  );

  // ---------------- pending flags ----------------
  logic [3:0] pending;

  clkroot_dirty_track #(.NREG(4)) u_dirty (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (wr_to_pending(sh_wr)),
    .clr_i   (commit),
    .dirty_o (pending)
  );

  // ---------------- active set ----------------
  logic [2:0][MND_W-1:0] act_mnd;

  clkroot_active_bank #(.DIV_W(DIV_W), .MND_W(MND_W)) u_active (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (commit),
    .div_i  (sh_div),
    .src_i  (sh_src),
    .mode_i (sh_mode),
    .mnd_i  (sh_mnd),
    .div_o  (act_prediv_o),
    .src_o  (act_src_o),
    .mode_o (act_mode_o),
    .mnd_o  (act_mnd)
  );

  assign act_m_o = act_mnd[0];
  assign act_n_o = act_mnd[1];
  assign act_d_o = act_mnd[2];

  // ---------------- root enable ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      root_en_o <= 1'b0;
    else if (wr_cmd) root_en_o <= bus_wdata[1];
  end

  // ---------------- read mux ----------------
  always_comb begin
    unique case (word)
      WORD_W'(W_CMD): bus_rdata = {root_off_i, 23'b0, pending, 2'b0, root_en_o, upd_busy};
      WORD_W'(W_CFG): bus_rdata = pack_cfg(8'(sh_div), sh_src, sh_mode);
      WORD_W'(W_M):   bus_rdata = 32'(sh_mnd[0]);
      WORD_W'(W_N):   bus_rdata = 32'(sh_mnd[1]);
      WORD_W'(W_D):   bus_rdata = 32'(sh_mnd[2]);
      default:        bus_rdata = '0;
    endcase
  end

  // ---------------- assertions ----------------
  // R4: the commit copies the shadow values of the cycle before, all at once
  a_r4_atomic_copy: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (act_m_o == $past(sh_mnd[0]) && act_n_o == $past(sh_mnd[1]) &&
                act_d_o == $past(sh_mnd[2]) && act_prediv_o == $past(sh_div) &&
                act_src_o == $past(sh_src) && act_mode_o == $past(sh_mode)));

  // R3: a configuration write raises the configuration flag
  a_r3_cfg_flag: assert property (@(posedge clk) disable iff (!rst_n)
    sh_wr[0] |=> pending[0]);

  // R7: root enable follows the written bit
  a_r7_enable_follows: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd |=> (root_en_o == $past(bus_wdata[1])));

endmodule

// File: tb/tb_clkroot_cfg_regs.sv
`timescale 1ns/1ps
module tb_clkroot_cfg_regs;

  localparam int DIV_W = 5;
  localparam int MND_W = 8;
  localparam logic [31:0] CFG_MASK = 32'h0000_371F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr_en = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        root_off_i = 1'b1;
  logic        root_en_o;
  logic [DIV_W-1:0] act_prediv_o;
  logic [2:0]  act_src_o;
  logic [1:0]  act_mode_o;
  logic [MND_W-1:0] act_m_o, act_n_o, act_d_o;

  always #10 clk = ~clk;   // 50 MHz

  clkroot_cfg_regs #(.DIV_W(DIV_W), .MND_W(MND_W), .ADDR_W(5)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .root_off_i(root_off_i),
    .root_en_o(root_en_o), .act_prediv_o(act_prediv_o), .act_src_o(act_src_o),
    .act_mode_o(act_mode_o), .act_m_o(act_m_o), .act_n_o(act_n_o), .act_d_o(act_d_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // bench model of the active set
  logic [31:0] m_cfg = '0;
  logic [31:0] m_mnd [3] = '{32'h0, 32'h0, 32'h0};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // caller sits at a falling edge; returns at the next falling edge
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] act_cfg_word();
    return {18'b0, act_mode_o, 1'b0, act_src_o, 3'b0, act_prediv_o};
  endfunction

  task automatic chk_active(input string tag);
    chk({tag, " cfg"}, act_cfg_word(), m_cfg);
    chk({tag, " M"}, 32'(act_m_o), m_mnd[0]);
    chk({tag, " N"}, 32'(act_n_o), m_mnd[1]);
    chk({tag, " D"}, 32'(act_d_o), m_mnd[2]);
  endtask

  // request update and follow it through to completion
  task automatic commit_and_check(input logic [31:0] new_cfg,
                                  input logic [31:0] nm, input logic [31:0] nn,
                                  input logic [31:0] nd);
    logic [31:0] r;
    wr(5'h00, 32'h1);
    rd(5'h00, r);
    chk("R4 update bit set", {31'b0, r[0]}, 32'h1);
    chk_active("R2 no change before commit");
    @(negedge clk);
    m_cfg = new_cfg; m_mnd[0] = nm; m_mnd[1] = nn; m_mnd[2] = nd;
    chk_active("R4 commit copy");
    rd(5'h00, r);
    chk("R4 flags cleared", {24'b0, r[7:4], 4'b0}, 32'h0);
    chk("R5 bit still up", {31'b0, r[0]}, 32'h1);
    @(negedge clk);
    rd(5'h00, r);
    chk("R5 bit dropped", {31'b0, r[0]}, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, g, sh_cfg, sh_m, sh_n, sh_d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(5'h00, r); chk("R1 cmd", r, 32'h8000_0000);
    rd(5'h04, r); chk("R1 cfg", r, 0);
    rd(5'h08, r); chk("R1 M", r, 0);
    rd(5'h0C, r); chk("R1 N", r, 0);
    rd(5'h10, r); chk("R1 D", r, 0);
    chk("R1 enable", {31'b0, root_en_o}, 0);
    chk_active("R1 active");

    // R8 status bit follows input
    root_off_i = 1'b0;
    rd(5'h00, r); chk("R8 status running", r, 32'h0);

    // R7/R9 enable and ignored command bits, bit0 = 0
    wr(5'h00, 32'hFFFF_FFFE);
    chk("R7 enable out", {31'b0, root_en_o}, 1);
    rd(5'h00, r); chk("R9 cmd readback", r, 32'h2);
    @(negedge clk);
    rd(5'h00, r); chk("R9 no update started", r, 32'h2);
    chk_active("R9 active untouched");
    wr(5'h00, 32'h0);
    chk("R7 enable off", {31'b0, root_en_o}, 0);

    // R10 unmapped words
    for (int a = 5; a < 8; a++) begin
      wr(5'(a * 4), 32'hFFFF_FFFF);
      rd(5'(a * 4), r); chk("R10 unmapped reads 0", r, 0);
    end
    rd(5'h00, r); chk("R10 no flags", r, 0);
    rd(5'h04, r); chk("R10 cfg untouched", r, 0);
    rd(5'h08, r); chk("R10 M untouched", r, 0);
    rd(5'h0C, r); chk("R10 N untouched", r, 0);
    rd(5'h10, r); chk("R10 D untouched", r, 0);

    // R2/R3/R8 exhaustive configuration field sweep
    sh_m = 0; sh_n = 0; sh_d = 0;
    for (int i = 0; i < 1024; i++) begin
      g = (32'(i) * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
      sh_cfg = 32'(i % 32) | (32'((i / 32) % 8) << 8) | (32'(i / 256) << 12);
      wr(5'h04, (g & ~CFG_MASK) | sh_cfg);
      rd(5'h04, r); chk("R8 cfg fields/mask", r, sh_cfg);
      rd(5'h00, r); chk("R3 cfg flag bit4", {24'b0, r[7:4], 4'b0}, 32'h10);
      chk_active("R2 cfg held");
      commit_and_check(sh_cfg, sh_m, sh_n, sh_d);
    end

    // R2/R3/R8 all M, N, D values
    for (int k = 0; k < 3; k++) begin
      for (int v = 0; v < 256; v++) begin
        logic [31:0] flag;
        g = (32'(v + k * 256) * 32'h85EB_CA6B) | 32'h0100_0000;
        flag = (k == 0) ? 32'h40 : (k == 1) ? 32'h20 : 32'h80;
        wr(5'(8 + 4 * k), (g & 32'hFFFF_FF00) | 32'(v));
        rd(5'(8 + 4 * k), r); chk("R8 MND width mask", r, 32'(v));
        rd(5'h00, r); chk("R3 MND flag order", {24'b0, r[7:4], 4'b0}, flag);
        chk_active("R2 MND held");
        if (k == 0) sh_m = 32'(v);
        else if (k == 1) sh_n = 32'(v);
        else sh_d = 32'(v);
        commit_and_check(sh_cfg, sh_m, sh_n, sh_d);
      end
    end

    // R3 several flags at once
    wr(5'h04, 32'h0000_2005);
    wr(5'h10, 32'h0000_0033);
    rd(5'h00, r); chk("R3 cfg+D flags", {24'b0, r[7:4], 4'b0}, 32'h90);
    commit_and_check(32'h0000_2005, sh_m, sh_n, 32'h33);

    // R6 write on the commit edge
    wr(5'h08, 32'h11);
    commit_and_check(32'h0000_2005, 32'h11, sh_n, 32'h33);
    wr(5'h00, 32'h1);
    wr(5'h08, 32'h22);          // captured on the commit edge
    chk_active("R6 commit took old M");
    rd(5'h00, r); chk("R6 M flag kept", {24'b0, r[7:4], 4'b0}, 32'h40);
    rd(5'h08, r); chk("R6 shadow holds new M", r, 32'h22);
    @(negedge clk);
    rd(5'h00, r); chk("R5 idle after R6 case", {31'b0, r[0]}, 0);
    commit_and_check(32'h0000_2005, 32'h22, sh_n, 32'h33);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule